// File: doc/BRIEF.md
# Masked 320-bit Lightweight Permutation Core

This core evaluates the standardized 320-bit lightweight-cryptography sponge permutation (five 64-bit words x0..x4) on a state that is split into Boolean shares. It protects the computation against power analysis. The masking order is fixed at elaboration by `ORDER`: order 1 keeps two shares and order 2 keeps three. The nonlinear layer is built from domain-oriented masking AND gates. Every gate takes a fresh random bit for each pair of share domains.

Each round spans two clock cycles. In the first cycle, the round constant and the first affine layer are computed and captured on the falling clock edge. The independent-input products are then formed and captured on the next rising edge. Fresh randomness is sampled at that rising edge only. In the second cycle, the products are compressed and the second affine layer and the linear diffusion are applied. The new state is written on the rising edge that ends the round. The `FULL_DOM_REG` parameter selects how the products are registered. When it is 1, both the same-domain and the cross-domain products are registered. When it is 0, only the cross-domain products are registered, and the same-domain products are formed again from the falling-edge register during the second cycle.

All shares are loaded together, in parallel, when a run starts, and they are read out together from `state_out`. Loading and reading therefore add no cycles. The core has no valid/ready handshake and applies no back-pressure. A start is accepted in any idle cycle. The result stays on `state_out` until the next accepted start, so a consumer can take it at any time after `done`.

Top module: `mperm_core`

## Requirements
- R1: With ORDER=1 (two shares) and with ORDER=2 (three shares), the XOR of all output shares equals the unmasked permutation of the XOR of the loaded shares, for any split of the state into shares.
- R2: When `short_run`=0 at start, the core applies 12 rounds with round indices 0..11. Round i adds the constant {4'(15-i), 4'(i)} to the low byte of word x2, in share 0 only.
- R3: When `short_run`=1 at start, the core applies 6 rounds with round indices 6..11 and the same constant rule.
- R4: Every round takes exactly two cycles. `done` is high for exactly one cycle, in the cycle after the rising edge that lies 2·N edges after the start edge (N = 12 or 6).
- R5: A `start` that arrives while a run is in progress is ignored. It changes neither the result nor the latency of that run.
- R6: On an accepted start, `state_in` is copied to `state_out` at the start edge. Share s occupies bits [320s+319:320s], and word xk of a share occupies bits [64k+63:64k]. After `done`, `state_out` holds its value until the next accepted start.
- R7: After reset, `done` is 0 and `state_out` is all zeros.
- R8: The unmasked result does not depend on the values driven on `rnd`. A new random word is sampled once per round, at the end of the round's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the affine register uses its falling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run and capture `state_in` when idle |
| short_run | input | 1 | 1 selects 6 rounds, 0 selects 12 rounds |
| state_in | input | 320·(ORDER+1) | Shared state loaded at start |
| rnd | input | 320·ORDER·(ORDER+1)/2 | Fresh randomness, 320 bits per share pair |
| state_out | output | 320·(ORDER+1) | Shared state register |
| done | output | 1 | One-cycle pulse after the final round |

## Verification
The assertions assume that `rnd` holds uniform, fresh bits at every rising edge. They also assume that `start` may be driven at any time, including during a run, and that the environment never needs a handshake at the edge of the block. To stay within these assumptions, the bench drives a new random word on every falling edge and splits each state into new random shares. It also pulses `start`, with different data and a different round select, in the middle of a run. Both masking orders run side by side on identical unmasked inputs. Each result is unmasked and compared with a behavioural unshared model.

// File: rtl/mperm_pkg.sv
package mperm_pkg;
  localparam int WW = 64;
  localparam int NWORD = 5;
  localparam int SW = WW * NWORD;
  localparam int LAST_IDX = 11;
  localparam int SHORT_IDX = 6;

  function automatic logic [WW-1:0] ror(input logic [WW-1:0] v, input int n);
    return (v >> n) | (v << (WW - n));
  endfunction

  function automatic logic [7:0] round_const(input logic [3:0] i);
    return {4'hF - i, i};
  endfunction

  // linear diffusion of one share, word-wise rotations
  function automatic logic [SW-1:0] diffuse(input logic [SW-1:0] s);
    logic [SW-1:0] o;
    int ra [NWORD];
    int rb [NWORD];
    ra = '{19, 61, 1, 10, 7};
    rb = '{28, 39, 6, 17, 41};
    for (int k = 0; k < NWORD; k++) begin
      o[k*WW +: WW] = s[k*WW +: WW] ^ ror(s[k*WW +: WW], ra[k]) ^ ror(s[k*WW +: WW], rb[k]);
    end
    return o;
  endfunction

  // word k of result = word (k+1) mod 5 of input
  function automatic logic [SW-1:0] next_word(input logic [SW-1:0] s);
    return {s[WW-1:0], s[SW-1:WW]};
  endfunction

  function automatic int pair_index(input int i, input int j, input int nsh);
    return i * nsh - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/mperm_ctrl.sv
module mperm_ctrl
  import mperm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       short_run,
  output logic       busy,
  output logic       phase,
  output logic [3:0] idx,
  output logic       done,
  output logic       load,
  output logic       upd
);
  localparam logic [3:0] IDX_LAST  = 4'(LAST_IDX);
  localparam logic [3:0] IDX_SHORT = 4'(SHORT_IDX);

  assign load = start && !busy;
  assign upd  = busy && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= 1'b0;
          idx   <= short_run ? IDX_SHORT : 4'd0;
        end
      end else if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (idx == IDX_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 4'd1;
        end
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_phase_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase) |=> !phase);
  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase && start) |=> (busy && phase && idx == $past(idx)));
  p_short_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && short_run) |=> (idx == IDX_SHORT));
  p_full_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !short_run) |=> (idx == 4'd0));
endmodule

// File: rtl/mperm_affine.sv
module mperm_affine
  import mperm_pkg::*;
#(
  parameter int NSH = 2
) (
  input  logic             clk,
  input  logic [NSH*SW-1:0] state,
  input  logic [7:0]        rc,
  output logic [NSH*SW-1:0] aff_q
);
  function automatic logic [SW-1:0] first_affine(input logic [SW-1:0] s,
                                                 input logic first, input logic [7:0] c);
    logic [SW-1:0] w;
    w = s;
    if (first) w[2*WW +: 8] = w[2*WW +: 8] ^ c;
    w[0*WW +: WW] = w[0*WW +: WW] ^ w[4*WW +: WW];
    w[4*WW +: WW] = w[4*WW +: WW] ^ w[3*WW +: WW];
    w[2*WW +: WW] = w[2*WW +: WW] ^ w[1*WW +: WW];
    return w;
  endfunction

  logic [NSH*SW-1:0] aff_d;

  for (genvar s = 0; s < NSH; s++) begin : g_share
    assign aff_d[s*SW +: SW] = first_affine(state[s*SW +: SW], 1'(s == 0), rc);
  end

  // falling-edge stage: DOM-AND inputs settle glitch-free before products form
  always_ff @(negedge clk) aff_q <= aff_d;
endmodule

// File: rtl/mperm_dom.sv
module mperm_dom
  import mperm_pkg::*;
#(
  parameter int NSH = 2,
  parameter bit FULL_REG = 1'b1,
  localparam int NPAIR = NSH * (NSH - 1) / 2
) (
  input  logic                 clk,
  input  logic [NSH*SW-1:0]    aff,
  input  logic [NPAIR*SW-1:0]  rnd,
  output logic [NSH*SW-1:0]    prod
);
  logic [SW-1:0] a [NSH];
  logic [SW-1:0] b [NSH];
  logic [SW-1:0] inner [NSH];
  logic [SW-1:0] cross_q [NSH][NSH];

  always_comb begin
    for (int s = 0; s < NSH; s++) begin
      a[s] = aff[s*SW +: SW] ^ ((s == 0) ? {SW{1'b1}} : {SW{1'b0}});
      b[s] = next_word(aff[s*SW +: SW]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSH; i++) begin
      for (int j = 0; j < NSH; j++) begin
        if (i < j)
          cross_q[i][j] <= (a[i] & b[j]) ^ rnd[pair_index(i, j, NSH)*SW +: SW];
        else if (i > j)
          cross_q[i][j] <= (a[i] & b[j]) ^ rnd[pair_index(j, i, NSH)*SW +: SW];
        else
          cross_q[i][j] <= '0;
      end
    end
  end

  if (FULL_REG) begin : g_full
    always_ff @(posedge clk) begin
      for (int i = 0; i < NSH; i++) inner[i] <= a[i] & b[i];
    end
  end else begin : g_part
    always_comb begin
      for (int i = 0; i < NSH; i++) inner[i] = a[i] & b[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NSH; i++) begin
      prod[i*SW +: SW] = inner[i];
      for (int j = 0; j < NSH; j++) prod[i*SW +: SW] = prod[i*SW +: SW] ^ cross_q[i][j];
    end
  end
endmodule

// File: rtl/mperm_finish.sv
module mperm_finish
  import mperm_pkg::*;
#(
  parameter int NSH = 2
) (
  input  logic [NSH*SW-1:0] aff,
  input  logic [NSH*SW-1:0] prod,
  output logic [NSH*SW-1:0] nxt
);
  function automatic logic [SW-1:0] close_round(input logic [SW-1:0] x,
                                                input logic [SW-1:0] t, input logic first);
    logic [SW-1:0] w;
    w = x ^ next_word(t);
    w[1*WW +: WW] = w[1*WW +: WW] ^ w[0*WW +: WW];
    w[0*WW +: WW] = w[0*WW +: WW] ^ w[4*WW +: WW];
    w[3*WW +: WW] = w[3*WW +: WW] ^ w[2*WW +: WW];
    if (first) w[2*WW +: WW] = ~w[2*WW +: WW];
    return diffuse(w);
  endfunction

  for (genvar s = 0; s < NSH; s++) begin : g_share
    assign nxt[s*SW +: SW] = close_round(aff[s*SW +: SW], prod[s*SW +: SW], 1'(s == 0));
  end
endmodule

// File: rtl/mperm_core.sv
module mperm_core
  import mperm_pkg::*;
#(
  parameter int ORDER = 1,
  parameter bit FULL_DOM_REG = 1'b1,
  localparam int NSH = ORDER + 1,
  localparam int NPAIR = NSH * (NSH - 1) / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                short_run,
  input  logic [NSH*SW-1:0]   state_in,
  input  logic [NPAIR*SW-1:0] rnd,
  output logic [NSH*SW-1:0]   state_out,
  output logic                done
);
  logic busy, phase, load, upd;
  logic [3:0] idx;
  logic [NSH*SW-1:0] aff, prod, nxt;

  mperm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .short_run(short_run),
    .busy(busy), .phase(phase), .idx(idx), .done(done), .load(load), .upd(upd)
  );

  mperm_affine #(.NSH(NSH)) u_aff (
    .clk(clk), .state(state_out), .rc(round_const(idx)), .aff_q(aff)
  );

  mperm_dom #(.NSH(NSH), .FULL_REG(FULL_DOM_REG)) u_dom (
    .clk(clk), .aff(aff), .rnd(rnd), .prod(prod)
  );

  mperm_finish #(.NSH(NSH)) u_fin (
    .aff(aff), .prod(prod), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_out <= '0;
    else if (load) state_out <= state_in;
    else if (upd)  state_out <= nxt;
  end

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(state_out));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (state_out == $past(state_in)));
  p_first_cycle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase) |=> $stable(state_out));
endmodule

// File: tb/mperm_core_tb.sv
`timescale 1ns/1ps
module mperm_core_tb;
  localparam int SW = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic short_run = 1'b0;
  logic [2*SW-1:0] in1 = '0, out1;
  logic [3*SW-1:0] in2 = '0, out2;
  logic [SW-1:0]   rnd1 = '0;
  logic [3*SW-1:0] rnd2 = '0;
  logic done1, done2;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mperm_core #(.ORDER(1), .FULL_DOM_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .short_run(short_run),
    .state_in(in1), .rnd(rnd1), .state_out(out1), .done(done1)
  );
  mperm_core #(.ORDER(2), .FULL_DOM_REG(1'b0)) u_dut_o2 (
    .clk(clk), .rst_n(rst_n), .start(start), .short_run(short_run),
    .state_in(in2), .rnd(rnd2), .state_out(out2), .done(done2)
  );

  function automatic logic [SW-1:0] r320();
    logic [SW-1:0] v;
    for (int k = 0; k < 10; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] rr(input logic [63:0] v, input int n);
    logic [127:0] d;
    d = {v, v} >> n;
    return d[63:0];
  endfunction

  function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] s, input int nr);
    logic [63:0] x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
    {x4, x3, x2, x1, x0} = s;
    for (int r = 12 - nr; r < 12; r++) begin
      x2 = x2 ^ 64'((15 - r) * 16 + r);
      x0 = x0 ^ x4; x4 = x4 ^ x3; x2 = x2 ^ x1;
      t0 = ~x0 & x1; t1 = ~x1 & x2; t2 = ~x2 & x3; t3 = ~x3 & x4; t4 = ~x4 & x0;
      x0 = x0 ^ t1; x1 = x1 ^ t2; x2 = x2 ^ t3; x3 = x3 ^ t4; x4 = x4 ^ t0;
      x1 = x1 ^ x0; x0 = x0 ^ x4; x3 = x3 ^ x2; x2 = ~x2;
      x0 = x0 ^ rr(x0, 19) ^ rr(x0, 28);
      x1 = x1 ^ rr(x1, 61) ^ rr(x1, 39);
      x2 = x2 ^ rr(x2, 1)  ^ rr(x2, 6);
      x3 = x3 ^ rr(x3, 10) ^ rr(x3, 17);
      x4 = x4 ^ rr(x4, 7)  ^ rr(x4, 41);
    end
    return {x4, x3, x2, x1, x0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                     input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fresh randomness every cycle
  initial forever begin
    @(negedge clk);
    rnd1 = r320();
    rnd2 = {r320(), r320(), r320()};
  end

  // runs one permutation on both orders; poke pulses start mid-run
  task automatic run(input logic [SW-1:0] x, input logic sh, input bit poke,
                     output int lat, output logic [SW-1:0] y1, output logic [SW-1:0] y2);
    logic [SW-1:0] a, b, c;
    a = r320(); b = r320(); c = r320();
    in1 = {x ^ a, a};
    in2 = {x ^ b ^ c, c, b};
    start = 1'b1; short_run = sh;
    @(negedge clk);
    start = 1'b0;
    chk(out1 == {x ^ a, a}, "R6 load order1", out1[SW-1:0], a);
    chk(out2 == {x ^ b ^ c, c, b}, "R6 load order2", out2[SW-1:0], b);
    lat = 0;
    while (!done1 && lat < 100) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 3) begin
        start = 1'b1; short_run = ~sh; in1 = ~in1; in2 = ~in2;
      end
      if (lat == 5) start = 1'b0;
    end
    chk(done2 == done1, "R4 done both orders", SW'(done2), SW'(done1));
    y1 = out1[SW-1:0] ^ out1[2*SW-1:SW];
    y2 = out2[SW-1:0] ^ out2[2*SW-1:SW] ^ out2[3*SW-1:2*SW];
  endtask

  localparam logic [SW:0] VEC [6] = '{
    {1'b0, {SW{1'b0}}},
    {1'b1, {SW{1'b0}}},
    {1'b0, {SW{1'b1}}},
    {1'b1, {5{64'h0123456789abcdef}}},
    {1'b0, {10{32'hdeadbeef}}},
    {1'b1, {40{8'h5a}}}
  };

  initial begin
    int lat;
    logic [SW-1:0] y1, y2, e, hold1, r1;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done1 == 1'b0, "R7 done after reset", SW'(done1), '0);
    chk(out1 == '0, "R7 state after reset", out1[SW-1:0], '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int n;
      n = VEC[v][SW] ? 6 : 12;
      e = ref_perm(VEC[v][SW-1:0], n);
      run(VEC[v][SW-1:0], VEC[v][SW], 1'b0, lat, y1, y2);
      chk(y1 == e, VEC[v][SW] ? "R3 order1 six rounds" : "R2 order1 twelve rounds", y1, e);
      chk(y2 == e, "R1 order2 result", y2, e);
      chk(lat == 2 * n, "R4 latency", SW'(lat), SW'(2 * n));
      @(negedge clk);
      chk(done1 == 1'b0, "R4 done single pulse", SW'(done1), '0);
    end

    // R6 hold after done
    e = ref_perm({5{64'hfedcba9876543210}}, 12);
    run({5{64'hfedcba9876543210}}, 1'b0, 1'b0, lat, y1, y2);
    hold1 = out1[SW-1:0];
    repeat (7) @(negedge clk);
    chk(out1[SW-1:0] == hold1, "R6 hold after done", out1[SW-1:0], hold1);
    chk((out1[SW-1:0] ^ out1[2*SW-1:SW]) == e, "R6 held value", out1[SW-1:0] ^ out1[2*SW-1:SW], e);

    // R5 start while busy ignored
    e = ref_perm({10{32'h13579bdf}}, 12);
    run({10{32'h13579bdf}}, 1'b0, 1'b1, lat, y1, y2);
    chk(y1 == e, "R5 busy start ignored result", y1, e);
    chk(y2 == e, "R5 busy start ignored order2", y2, e);
    chk(lat == 24, "R5 busy start ignored latency", SW'(lat), SW'(24));
    @(negedge clk);

    // R8 same input, different randomness and sharing
    e = ref_perm({5{64'h00000000ffffffff}}, 6);
    run({5{64'h00000000ffffffff}}, 1'b1, 1'b0, lat, r1, y2);
    @(negedge clk);
    run({5{64'h00000000ffffffff}}, 1'b1, 1'b0, lat, y1, y2);
    chk(y1 == r1, "R8 randomness independence", y1, r1);
    chk(y2 == e, "R8 order2 result", y2, e);

    // R2 random states
    for (int k = 0; k < 4; k++) begin
      logic [SW-1:0] s;
      s = r320();
      e = ref_perm(s, 12);
      run(s, 1'b0, 1'b0, lat, y1, y2);
      chk(y1 == e && y2 == e, "R2 random state", y1, e);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule